// File: doc/BRIEF.md
# Flash Emulation RAM Overlay Controller

This controller lets a 4 KB window of on-chip RAM stand in for one 4 KB block of flash. Software tunes constants or code in RAM while the CPU still fetches and reads them at flash addresses. An overlay control register holds an enable bit and a three-bit block number. While the overlay is on, every CPU address that falls inside the chosen flash block is steered to RAM, and the low twelve address bits become the RAM offset. The RAM also stays reachable at its own fixed page, 0xFFD000 to 0xFFDFFF, so both views reach the same storage.

The block also guards flash program and erase mode entry. A flash control register holds a program request bit and an erase request bit. While the overlay is enabled, neither mode can be entered for any flash block. This protection does not depend on which block is overlaid. When the overlay is released, requests work normally. The two modes never run together. The address decode is purely combinational. The registers and the mode state are clocked and reset to zero.

Top module: `flash_overlay_ctrl`

## Requirements
- R1: After reset, both registers read zero, no address is steered by the overlay, and neither program mode nor erase mode is active.
- R2: With the enable bit (overlay register bit 7) set and block number N in bits 2:0, any address whose bits 23:12 equal N routes to RAM (`route_ram`=1, `route_flash`=0), and `ram_offset` equals address bits 11:0.
- R3: Addresses 0xFFD000 to 0xFFDFFF always route to RAM, with `ram_offset` equal to address bits 11:0, whatever the overlay state.
- R4: Addresses below 0x40000 that are not overlaid route to flash. This includes unselected blocks 0 to 7 and all of blocks 8 and above. Any address that is neither flash nor RAM drives both route outputs low. `ram_offset` is 0 whenever `route_ram` is 0.
- R5: Clearing the enable bit returns the previously overlaid block to flash on the next cycle's decode.
- R6: While the enable bit is set, program and erase modes are both inactive from the next clock on, for every block number. A mode that was active drops within one clock of the overlay being enabled.
- R7: With the overlay disabled, a stored program request (flash control bit 0) alone enters program mode one clock after it is written. An erase request (bit 1) alone enters erase mode in the same way. Clearing the request leaves the mode one clock later.
- R8: Program and erase modes are never active together. If both request bits are 1, neither mode is entered.
- R9: Reads return the stored bits: overlay register {enable, 4'b0, block}. The flash control register reads {2'b0, erase mode, program mode, 2'b0, erase request, program request}. The mode bits show the mode actually entered. Writes to the status and unused bits are ignored.
- R10: `route_ram` and `route_flash` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 overlay register, 1 flash control register |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the selected register (combinational) |
| bus_addr | input | 24 | CPU bus address to decode |
| route_ram | output | 1 | Access goes to the emulation RAM |
| route_flash | output | 1 | Access goes to the flash array |
| ram_offset | output | 12 | Byte offset into the RAM window |
| prog_mode | output | 1 | Flash program mode active |
| erase_mode | output | 1 | Flash erase mode active |

## Verification
Suppose the stored enable bit or block number were wrong. The error would show on the very next decode: an address in the chosen block would come out on `route_flash`, or a neighbouring block would go to RAM. A broken readback exposes the same error through `reg_rdata` with no clock delay. A wrong mode state shows one clock after a request or an overlay change, on `prog_mode`, `erase_mode` and the status bits. The bench therefore samples the modes one clock after each write. It checks the decode at the negative edge after each register update.

// File: rtl/feo_pkg.sv
package feo_pkg;
  localparam int unsigned DEF_ADDR_W      = 24;
  localparam int unsigned DEF_OFS_W       = 12;
  localparam int unsigned DEF_SEL_W       = 3;
  localparam int unsigned DEF_REG_W       = 8;
  localparam int unsigned DEF_RAM_PAGE    = 32'hFFD;
  localparam int unsigned DEF_FLASH_PAGES = 64;

  // Register bit positions (behavioural: software encodes against them)
  localparam int unsigned OVL_EN_BIT    = 7;
  localparam int unsigned FCTL_PE_BIT   = 0;
  localparam int unsigned FCTL_EE_BIT   = 1;
  localparam int unsigned FCTL_PSTS_BIT = 4;
  localparam int unsigned FCTL_ESTS_BIT = 5;

  typedef enum logic {
    SEL_OVERLAY = 1'b0,
    SEL_FCTL    = 1'b1
  } reg_sel_e;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_PROG  = 2'd1,
    MODE_ERASE = 2'd2
  } flash_mode_e;
endpackage

// File: rtl/feo_ctrl_regs.sv
module feo_ctrl_regs
  import feo_pkg::*;
#(
  parameter int unsigned SEL_W = DEF_SEL_W,
  parameter int unsigned REG_W = DEF_REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic             sel,
  input  logic [REG_W-1:0] wdata,
  input  logic             prog_sts,
  input  logic             erase_sts,
  output logic [REG_W-1:0] rdata,
  output logic             ovl_en,
  output logic [SEL_W-1:0] ovl_blk,
  output logic             pe_req,
  output logic             ee_req
);
  logic wr_ovl;
  logic wr_fctl;

  assign wr_ovl  = wr_stb && (sel == SEL_OVERLAY);
  assign wr_fctl = wr_stb && (sel == SEL_FCTL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovl_en  <= 1'b0;
      ovl_blk <= '0;
      pe_req  <= 1'b0;
      ee_req  <= 1'b0;
    end else begin
      if (wr_ovl) begin
        ovl_en  <= wdata[OVL_EN_BIT];
        ovl_blk <= wdata[SEL_W-1:0];
      end
      if (wr_fctl) begin
        pe_req <= wdata[FCTL_PE_BIT];
        ee_req <= wdata[FCTL_EE_BIT];
      end
    end
  end

  function automatic logic [REG_W-1:0] pack_ovl(input logic en, input logic [SEL_W-1:0] blk);
    logic [REG_W-1:0] v;
    v = '0;
    v[OVL_EN_BIT]  = en;
    v[SEL_W-1:0]   = blk;
    return v;
  endfunction

  function automatic logic [REG_W-1:0] pack_fctl(input logic pe, input logic ee,
                                                 input logic ps, input logic es);
    logic [REG_W-1:0] v;
    v = '0;
    v[FCTL_PE_BIT]   = pe;
    v[FCTL_EE_BIT]   = ee;
    v[FCTL_PSTS_BIT] = ps;
    v[FCTL_ESTS_BIT] = es;
    return v;
  endfunction

  always_comb begin
    if (sel == SEL_OVERLAY) rdata = pack_ovl(ovl_en, ovl_blk);
    else                    rdata = pack_fctl(pe_req, ee_req, prog_sts, erase_sts);
  end

  // A write to the overlay register is visible in the stored enable one clock later
  assert_ovl_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ovl |=> (ovl_en == $past(wdata[OVL_EN_BIT])));
  assert_fctl_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fctl |=> (pe_req == $past(wdata[FCTL_PE_BIT])) && (ee_req == $past(wdata[FCTL_EE_BIT])));
endmodule

// File: rtl/feo_mode_gate.sv
module feo_mode_gate
  import feo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pe_req,
  input  logic ee_req,
  input  logic ovl_en,
  output logic prog_mode,
  output logic erase_mode
);
  flash_mode_e mode_q;
  flash_mode_e mode_d;
  logic        entry_blocked;
  logic        req_conflict;

  assign entry_blocked = ovl_en;
  assign req_conflict  = pe_req && ee_req;

  always_comb begin
    mode_d = MODE_IDLE;
    if (!entry_blocked && !req_conflict) begin
      if (pe_req)      mode_d = MODE_PROG;
      else if (ee_req) mode_d = MODE_ERASE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= MODE_IDLE;
    else        mode_q <= mode_d;
  end

  assign prog_mode  = (mode_q == MODE_PROG);
  assign erase_mode = (mode_q == MODE_ERASE);

  assert_protect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    entry_blocked |=> !prog_mode && !erase_mode);
  assert_excl_modes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_mode && erase_mode));
  assert_conflict_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_conflict |=> !prog_mode && !erase_mode);
  assert_prog_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_req && !ee_req && !entry_blocked) |=> prog_mode);
  assert_erase_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_req && !pe_req && !entry_blocked) |=> erase_mode);
endmodule

// File: rtl/feo_addr_decode.sv
module feo_addr_decode
  import feo_pkg::*;
#(
  parameter int unsigned ADDR_W      = DEF_ADDR_W,
  parameter int unsigned OFS_W       = DEF_OFS_W,
  parameter int unsigned SEL_W       = DEF_SEL_W,
  parameter int unsigned RAM_PAGE    = DEF_RAM_PAGE,
  parameter int unsigned FLASH_PAGES = DEF_FLASH_PAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ovl_en,
  input  logic [SEL_W-1:0]  ovl_blk,
  output logic              route_ram,
  output logic              route_flash,
  output logic [OFS_W-1:0]  ram_offset
);
  localparam int unsigned PAGE_W = ADDR_W - OFS_W;

  logic [PAGE_W-1:0] page;
  logic              hit_overlay;
  logic              hit_native;
  logic              in_flash;

  function automatic logic [PAGE_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFS_W];
  endfunction

  function automatic logic [PAGE_W-1:0] block_page(input logic [SEL_W-1:0] blk);
    return PAGE_W'(blk);
  endfunction

  function automatic logic flash_page(input logic [PAGE_W-1:0] p);
    return 32'(p) < FLASH_PAGES;
  endfunction

  assign page        = page_of(addr);
  assign hit_overlay = ovl_en && (page == block_page(ovl_blk));
  assign hit_native  = (page == PAGE_W'(RAM_PAGE));
  assign in_flash    = flash_page(page);

  assign route_ram   = hit_overlay || hit_native;
  assign route_flash = in_flash && !route_ram;
  assign ram_offset  = route_ram ? addr[OFS_W-1:0] : '0;

  assert_route_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(route_ram && route_flash));
  assert_native_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_native |-> route_ram && (ram_offset == addr[OFS_W-1:0]));
  assert_overlay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_overlay |-> route_ram && !route_flash);
  assert_offset_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !route_ram |-> (ram_offset == '0));
endmodule

// File: rtl/flash_overlay_ctrl.sv
module flash_overlay_ctrl
  import feo_pkg::*;
#(
  parameter int unsigned ADDR_W      = DEF_ADDR_W,
  parameter int unsigned OFS_W       = DEF_OFS_W,
  parameter int unsigned SEL_W       = DEF_SEL_W,
  parameter int unsigned REG_W       = DEF_REG_W,
  parameter int unsigned RAM_PAGE    = DEF_RAM_PAGE,
  parameter int unsigned FLASH_PAGES = DEF_FLASH_PAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              route_ram,
  output logic              route_flash,
  output logic [OFS_W-1:0]  ram_offset,
  output logic              prog_mode,
  output logic              erase_mode
);
  logic             ovl_en;
  logic [SEL_W-1:0] ovl_blk;
  logic             pe_req;
  logic             ee_req;

  feo_ctrl_regs #(.SEL_W(SEL_W), .REG_W(REG_W)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (reg_wr),
    .sel       (reg_sel),
    .wdata     (reg_wdata),
    .prog_sts  (prog_mode),
    .erase_sts (erase_mode),
    .rdata     (reg_rdata),
    .ovl_en    (ovl_en),
    .ovl_blk   (ovl_blk),
    .pe_req    (pe_req),
    .ee_req    (ee_req)
  );

  feo_mode_gate gate_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pe_req     (pe_req),
    .ee_req     (ee_req),
    .ovl_en     (ovl_en),
    .prog_mode  (prog_mode),
    .erase_mode (erase_mode)
  );

  feo_addr_decode #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .SEL_W(SEL_W),
    .RAM_PAGE(RAM_PAGE), .FLASH_PAGES(FLASH_PAGES)
  ) dec_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (bus_addr),
    .ovl_en      (ovl_en),
    .ovl_blk     (ovl_blk),
    .route_ram   (route_ram),
    .route_flash (route_flash),
    .ram_offset  (ram_offset)
  );

  // Release: a block that was overlaid goes back to flash once enable is stored low
  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovl_en && (bus_addr[ADDR_W-1:OFS_W] < FLASH_PAGES)) |-> route_flash && !route_ram);
endmodule

// File: tb/flash_overlay_ctrl_tb.sv
`timescale 1ns/1ps
module flash_overlay_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [23:0] bus_addr = '0;
  logic        route_ram, route_flash, prog_mode, erase_mode;
  logic [11:0] ram_offset;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flash_overlay_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_addr(bus_addr),
    .route_ram(route_ram), .route_flash(route_flash), .ram_offset(ram_offset),
    .prog_mode(prog_mode), .erase_mode(erase_mode)
  );

  // Bench model state
  bit       m_en;
  bit [2:0] m_blk;
  bit       m_pe, m_ee;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Expected routing: {ram, flash, offset}
  function automatic logic [13:0] exp_route(input logic [23:0] a, input bit en, input bit [2:0] blk);
    bit ram;
    bit fl;
    ram = (a >= 24'hFFD000 && a <= 24'hFFDFFF) ||
          (en && a >= {9'd0, blk, 12'd0} && a < ({9'd0, blk, 12'd0} + 24'h1000));
    fl  = !ram && (a < 24'h40000);
    return {ram, fl, (ram ? a[11:0] : 12'h000)};
  endfunction

  function automatic logic [1:0] exp_modes(input bit en, input bit pe, input bit ee);
    if (en || (pe && ee)) return 2'b00;
    return {ee, pe}; // {erase, prog}
  endfunction

  task automatic wr(input bit sel, input logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    if (sel == 1'b0) begin m_en = d[7]; m_blk = d[2:0]; end
    else begin m_pe = d[0]; m_ee = d[1]; end
  endtask

  task automatic chk_addr(input string req, input logic [23:0] a);
    bus_addr = a;
    #2;
    chk(req, {18'd0, route_ram, route_flash, ram_offset}, {18'd0, exp_route(a, m_en, m_blk)});
  endtask

  task automatic chk_modes(input string req);
    logic [1:0] e;
    @(negedge clk); // one more clock for the mode register
    e = exp_modes(m_en, m_pe, m_ee);
    chk(req, {30'd0, erase_mode, prog_mode}, {30'd0, e});
    reg_sel = 1'b1; #2;
    chk({req, " readback"}, {24'd0, reg_rdata},
        {24'd0, 2'b00, e[1], e[0], 2'b00, m_ee, m_pe});
  endtask

  function automatic logic [23:0] pick_addr(input bit [2:0] blk);
    case ($urandom_range(0, 5))
      0: return {9'd0, blk, 12'($urandom)};
      1: return {12'hFFD, 12'($urandom)};
      2: return {9'd0, 3'($urandom), 12'($urandom)};
      3: return 24'($urandom_range(24'h08000, 24'h3FFFF));
      4: return 24'($urandom_range(24'h40000, 24'hFFFFFF));
      default: return {9'd0, blk, ($urandom_range(0, 1) ? 12'hFFF : 12'h000)};
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    m_en = 0; m_blk = 0; m_pe = 0; m_ee = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_sel = 1'b0; #2; chk("R1 ovl reg", {24'd0, reg_rdata}, 32'd0);
    reg_sel = 1'b1; #2; chk("R1 fctl reg", {24'd0, reg_rdata}, 32'd0);
    chk("R1 modes", {30'd0, erase_mode, prog_mode}, 32'd0);
    chk_addr("R1 block0 to flash", 24'h000123);

    // R2 overlay block 0, edges
    wr(1'b0, 8'h80);
    chk_addr("R2 blk0 low edge", 24'h000000);
    chk_addr("R2 blk0 high edge", 24'h000FFF);
    chk_addr("R4 blk1 stays flash", 24'h001000);
    chk_addr("R3 native ram", 24'hFFD456);
    // R9 unused bits ignored
    wr(1'b0, 8'hFD);
    reg_sel = 1'b0; #2; chk("R9 ovl readback", {24'd0, reg_rdata}, 32'h85);
    chk_addr("R2 blk5", 24'h005ABC);
    chk_addr("R4 blk8 flash", 24'h008000);
    chk_addr("R4 top of flash", 24'h03FFFF);
    chk_addr("R4 unmapped", 24'h040000);
    chk_addr("R4 just below ram", 24'hFFCFFF);
    // R5 release
    wr(1'b0, 8'h05);
    chk_addr("R5 released blk5", 24'h005ABC);

    // R7 entry
    wr(1'b1, 8'h01); chk_modes("R7 prog entry");
    wr(1'b1, 8'h02); chk_modes("R7 erase entry");
    wr(1'b1, 8'h00); chk_modes("R7 exit");
    // R8 both
    wr(1'b1, 8'h03); chk_modes("R8 both requested");
    // R9 status bits not writable
    wr(1'b1, 8'h30); chk_modes("R9 status write ignored");
    // R6 protection on each block; drop of active mode
    for (int b = 0; b < 8; b++) begin
      wr(1'b0, 8'h00);
      wr(1'b1, 8'h01); chk_modes("R7 prog before protect");
      wr(1'b0, 8'h80 | 8'(b));
      chk_modes("R6 mode dropped under overlay");
      wr(1'b1, 8'h02); chk_modes("R6 erase blocked");
    end
    wr(1'b0, 8'h00); chk_modes("R6 release re-enters");

    // Random mix
    for (int i = 0; i < 150; i++) begin
      wr(1'b0, {$urandom_range(0, 1) == 1, 4'b0, 3'($urandom)} | 8'($urandom & 8'h78));
      reg_sel = 1'b0; #2;
      chk("R9 random ovl readback", {24'd0, reg_rdata}, {24'd0, m_en, 4'b0, m_blk});
      for (int k = 0; k < 6; k++) begin
        logic [23:0] a;
        a = pick_addr(m_blk);
        chk_addr("R2/R3/R4 random route", a);
        chk("R10 exclusive routes", {31'd0, route_ram && route_flash}, 32'd0);
      end
      wr(1'b1, 8'($urandom));
      chk_modes("R6/R7/R8 random modes");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule